// File: doc/BRIEF.md
# Serial Switch-Status Reader with Interrupt-Mask Load

This block is the serial front end of a switch-monitoring input port. When the host selects it, the block takes a snapshot of the live switch levels into a status register. It then sends that snapshot out one bit at a time, most significant bit first. In the same transfer it takes in a new interrupt-enable mask from the host. The new mask is stored only when the host deselects the block. The interrupt compare logic that uses the mask is a separate block and is not part of this design.

The serial pins are oversampled by a fast system clock. Chip select, serial clock and serial data in each pass through a synchronizer, and their edges are found in the system clock domain. Every bit goes through a 16-stage shifter, so several devices can be chained, each one's serial output feeding the next one's serial input. A committed mask of all zeros acts as a software reset. It clears the status register and gives a one-cycle release pulse to the interrupt logic.

Top module: `spi_gpi_shifter`

## Requirements
- R1: After synchronous reset, `status_q` and `mask_q` are zero, and `sdo_oe` and `sdo` are low.
- R2: A falling edge on `cs_n` copies `pin_level` into `status_q`. At no other time does `status_q` change, except when a software reset clears it.
- R3: While selected, the first rising edge of `sclk` presents bit WIDTH-1 of the snapshot on `sdo`.
- R4: Each later rising edge of `sclk` presents the next lower snapshot bit. A 16-cycle transfer therefore reads the whole snapshot, MSB first.
- R5: `sdi` is captured on falling edges of `sclk`. After a 16-cycle transfer, `mask_q` holds the 16 bits sent, and the first bit sent lands in bit 15.
- R6: In a transfer longer than WIDTH cycles, the bit sent on cycle k reappears on `sdo` at rising edge k+WIDTH. `mask_q` keeps the last WIDTH bits sent.
- R7: A transfer with no `sclk` cycles commits the unchanged snapshot as the new mask.
- R8: While `cs_n` is high, activity on `sclk` and `sdi` changes neither `mask_q` nor `status_q`.
- R9: `sdo_oe` is high while the block is selected and low while it is deselected. `sdo` is low while deselected.
- R10: Committing an all-zero word makes `mask_q` and `status_q` zero and pulses `soft_rst` high for exactly one cycle.
- R11: `mask_q` holds steady for the whole time `cs_n` is low. It is loaded only at the rising edge of `cs_n`.
- R12: In a transfer shorter than WIDTH cycles of n bits, `mask_q` becomes the low WIDTH-n snapshot bits followed by the n bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the `sclk` rate |
| rst | input | 1 | Synchronous active-high reset |
| pin_level | input | WIDTH | Live switch levels, stable around `cs_n` falling |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, low at both `cs_n` edges |
| sdi | input | 1 | Serial data in (mask bits, MSB first) |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| status_q | output | WIDTH | Input status snapshot |
| mask_q | output | WIDTH | Committed interrupt-enable mask (1 = enabled) |
| soft_rst | output | 1 | One-cycle pulse when an all-zero mask is committed |

## Verification
The bench runs transfers of 16, 24, 8 and 0 clock cycles. Each one tests the alignment rule in its own way. A design that captured on the wrong edge, or added an extra shift stage, would read the snapshot shifted by one bit. A design that did not load the shifter at chip-select would commit garbage on the zero-cycle transfer. The bench also toggles the serial pins while the block is deselected and checks that the stored state is untouched. Last, it commits an all-zero word and checks that the status register is cleared and that the release pulse appears exactly once. A design that missed this would keep the old snapshot.

// File: rtl/spi_gpi_pkg.sv
package spi_gpi_pkg;
  // Synchronized level plus detected edges of one serial pin.
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } pin_ev_t;

  localparam int NUM_SER_PINS = 3;
  localparam int IDX_CS   = 0;
  localparam int IDX_SCLK = 1;
  localparam int IDX_SDI  = 2;
endpackage

// File: rtl/spi_gpi_sync.sv
module spi_gpi_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 din,
  output spi_gpi_pkg::pin_ev_t ev
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{RST_VAL}};
      last  <= RST_VAL;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      last  <= chain[STAGES-1];
    end
  end

  assign ev.level = chain[STAGES-1];
  assign ev.rise  = chain[STAGES-1] & ~last;
  assign ev.fall  = ~chain[STAGES-1] & last;
endmodule

// File: rtl/spi_gpi_core.sv
module spi_gpi_core #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_level,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             cs_act,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             sdi_lvl,
  output logic [WIDTH-1:0] status_q,
  output logic [WIDTH-1:0] mask_q,
  output logic             sdo_q,
  output logic             sdo_oe_q,
  output logic             soft_rst_q
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] shreg;
  logic             first_seen;
  logic             commit_zero;

  assign commit_zero = (shreg == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q   <= '0;
      mask_q     <= '0;
      shreg      <= '0;
      first_seen <= 1'b0;
      sdo_q      <= 1'b0;
      sdo_oe_q   <= 1'b0;
      soft_rst_q <= 1'b0;
    end else begin
      soft_rst_q <= 1'b0;
      sdo_oe_q   <= cs_act;
      if (cs_fall) begin
        status_q   <= pin_level;
        shreg      <= pin_level;   // zero-cycle transfer commits the snapshot
        first_seen <= 1'b0;
        sdo_q      <= 1'b0;
      end else if (cs_rise) begin
        mask_q <= shreg;
        sdo_q  <= 1'b0;
        if (commit_zero) begin
          status_q   <= '0;
          soft_rst_q <= 1'b1;
        end
      end else if (cs_act) begin
        if (sclk_rise) begin
          first_seen <= 1'b1;
          if (!first_seen) begin
            shreg <= status_q;
            sdo_q <= status_q[MSB];
          end else begin
            sdo_q <= shreg[MSB];
          end
        end else if (sclk_fall) begin
          shreg <= {shreg[MSB-1:0], sdi_lvl};
        end
      end
    end
  end
endmodule

// File: rtl/spi_gpi_shifter.sv
module spi_gpi_shifter #(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_level,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             sdi,
  output logic             sdo,
  output logic             sdo_oe,
  output logic [WIDTH-1:0] status_q,
  output logic [WIDTH-1:0] mask_q,
  output logic             soft_rst
);
  import spi_gpi_pkg::*;

  logic [NUM_SER_PINS-1:0] raw_pins;
  pin_ev_t                 ev [NUM_SER_PINS];
  logic                    cs_act;
  logic                    cs_fall;
  logic                    cs_rise;
  logic                    unused_sdi_edges;

  assign raw_pins[IDX_CS]   = cs_n;
  assign raw_pins[IDX_SCLK] = sclk;
  assign raw_pins[IDX_SDI]  = sdi;

  for (genvar g = 0; g < NUM_SER_PINS; g++) begin : g_sync
    // Chip select idles high; the other pins idle low.
    spi_gpi_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL((g == IDX_CS) ? 1'b1 : 1'b0)
    ) u_sync (
      .clk(clk),
      .rst(rst),
      .din(raw_pins[g]),
      .ev (ev[g])
    );
  end

  assign cs_act  = ~ev[IDX_CS].level;
  assign cs_fall = ev[IDX_CS].fall;
  assign cs_rise = ev[IDX_CS].rise;
  assign unused_sdi_edges = ev[IDX_SDI].rise ^ ev[IDX_SDI].fall;

  spi_gpi_core #(.WIDTH(WIDTH)) u_core (
    .clk       (clk),
    .rst       (rst),
    .pin_level (pin_level),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .cs_act    (cs_act),
    .sclk_rise (ev[IDX_SCLK].rise),
    .sclk_fall (ev[IDX_SCLK].fall),
    .sdi_lvl   (ev[IDX_SDI].level),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .sdo_q     (sdo),
    .sdo_oe_q  (sdo_oe),
    .soft_rst_q(soft_rst)
  );
endmodule

// File: rtl/spi_gpi_checker.sv
module spi_gpi_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_act,
  input logic             cs_fall,
  input logic [WIDTH-1:0] status_q,
  input logic [WIDTH-1:0] mask_q,
  input logic             sdo,
  input logic             sdo_oe,
  input logic             soft_rst
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (status_q == '0 && mask_q == '0 && !sdo_oe && !sdo));

  assert_status_only_at_edge_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(status_q) |-> ($past(cs_fall) || soft_rst));

  assert_oe_follows_select_R9: assert property (@(posedge clk) disable iff (rst)
    cs_act |=> sdo_oe);

  assert_oe_off_deselected_R9: assert property (@(posedge clk) disable iff (rst)
    (!cs_act && !sdo_oe) |-> !sdo);

  assert_soft_reset_clears_R10: assert property (@(posedge clk) disable iff (rst)
    soft_rst |-> (status_q == '0 && mask_q == '0));

  assert_soft_reset_single_R10: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> !soft_rst);

  assert_mask_stable_selected_R11: assert property (@(posedge clk) disable iff (rst)
    cs_act |=> (!cs_act || $stable(mask_q)));
endmodule

bind spi_gpi_shifter spi_gpi_checker #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cs_act  (cs_act),
  .cs_fall (cs_fall),
  .status_q(status_q),
  .mask_q  (mask_q),
  .sdo     (sdo),
  .sdo_oe  (sdo_oe),
  .soft_rst(soft_rst)
);

// File: tb/spi_gpi_shifter_tb.sv
module spi_gpi_shifter_tb;
  localparam int W    = 16;
  localparam int HALF = 8;   // system clocks per sclk half period

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] pin_level = '0;
  logic         cs_n = 1'b1;
  logic         sclk = 1'b0;
  logic         sdi  = 1'b0;
  logic         sdo, sdo_oe, soft_rst;
  logic [W-1:0] status_q, mask_q;

  always #2.5 clk = ~clk;   // 200 MHz

  spi_gpi_shifter #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .pin_level(pin_level), .cs_n(cs_n), .sclk(sclk),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .status_q(status_q),
    .mask_q(mask_q), .soft_rst(soft_rst)
  );

  int checks = 0;
  int fails  = 0;
  int sr_cnt = 0;
  bit finished = 0;

  always @(posedge clk) if (!rst && soft_rst) sr_cnt <= sr_cnt + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct {
    string        tag;
    int           n;
    logic [63:0]  exp_rd;
    logic [W-1:0] exp_mask;
    logic [W-1:0] exp_status;
  } item_t;

  item_t        sb_q[$];
  event         xfer_done;
  logic [63:0]  got_rd;

  // Driver: computes expectations, pushes them, then runs the transfer.
  task automatic xfer(input logic [W-1:0] pins, input int n, input logic [47:0] d,
                      input string tag);
    item_t        it;
    logic [79:0]  cat;
    logic [63:0]  rd = '0;
    logic [W-1:0] m_before;
    cat = ({64'b0, pins} << n) | {32'b0, d};
    it.tag        = tag;
    it.n          = n;
    it.exp_rd     = cat[79:16];
    it.exp_mask   = cat[15:0];
    it.exp_status = (cat[15:0] == '0) ? '0 : pins;
    sb_q.push_back(it);

    pin_level = pins;
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    check(sdo_oe === 1'b1, {tag, " R9 oe selected"}, 64'(sdo_oe), 64'd1);
    check(status_q === pins, {tag, " R2 snapshot"}, 64'(status_q), 64'(pins));
    m_before = mask_q;
    for (int i = 0; i < n; i++) begin
      sdi  = d[n-1-i];
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      rd = {rd[62:0], sdo};
      if (i == 0)
        check(sdo === pins[W-1], {tag, " R3 first bit is MSB"}, 64'(sdo), 64'(pins[W-1]));
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    check(mask_q === m_before, {tag, " R11 mask held while selected"},
          64'(mask_q), 64'(m_before));
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
    got_rd = rd;
    -> xfer_done;
    @(negedge clk);
  endtask

  // Monitor: pops the oldest expectation and compares against the design.
  initial begin
    forever begin
      @(xfer_done);
      begin
        item_t        it;
        logic [63:0]  msk;
        it  = sb_q.pop_front();
        msk = (it.n == 0) ? 64'd0 : (64'hFFFF_FFFF_FFFF_FFFF >> (64 - it.n));
        check((got_rd & msk) === (it.exp_rd & msk), {it.tag, " R4/R6 read stream"},
              got_rd & msk, it.exp_rd & msk);
        check(mask_q === it.exp_mask, {it.tag, " R5/R6/R7/R12 committed mask"},
              64'(mask_q), 64'(it.exp_mask));
        check(status_q === it.exp_status, {it.tag, " R2/R10 status after commit"},
              64'(status_q), 64'(it.exp_status));
        check(sdo_oe === 1'b0 && sdo === 1'b0, {it.tag, " R9 released"},
              64'({sdo_oe, sdo}), 64'd0);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [W-1:0] m_keep, s_keep;
    int           sr_before;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1: reset state
    check(status_q === '0 && mask_q === '0, "R1 reset registers", {32'(status_q), 32'(mask_q)}, 64'd0);
    check(sdo_oe === 1'b0 && sdo === 1'b0, "R1 R9 reset outputs", 64'({sdo_oe, sdo}), 64'd0);

    // R3 R4 R5: plain 16-cycle transfer
    xfer(16'hA5C3, 16, 48'h1234, "T16");
    // R6: 24-cycle transfer, chained data pass-through
    xfer(16'h0F0F, 24, 48'hABCDEF, "T24");
    // R7: zero-cycle transfer commits the snapshot
    xfer(16'h7E81, 0, 48'h0, "T0");
    // R12: short transfer
    xfer(16'hFFFF, 8, 48'h3C, "T8");

    // R8: serial activity while deselected is ignored
    m_keep = mask_q;
    s_keep = status_q;
    pin_level = 16'h5555;
    for (int i = 0; i < 5; i++) begin
      sdi = ~sdi; sclk = 1'b1; repeat (HALF) @(negedge clk);
      sclk = 1'b0; repeat (HALF) @(negedge clk);
    end
    check(mask_q === m_keep, "R8 mask untouched while deselected", 64'(mask_q), 64'(m_keep));
    check(status_q === s_keep, "R8 status untouched while deselected", 64'(status_q), 64'(s_keep));
    check(sdo_oe === 1'b0, "R9 oe low while deselected", 64'(sdo_oe), 64'd0);

    // R10: all-zero commit acts as software reset
    sr_before = sr_cnt;
    xfer(16'hBEEF, 16, 48'h0, "TSR");
    check(sr_cnt == sr_before + 1, "R10 single release pulse", 64'(sr_cnt - sr_before), 64'd1);

    // Non-zero commit after reset: no extra pulse
    sr_before = sr_cnt;
    xfer(16'h0001, 16, 48'h8001, "TAFTER");
    check(sr_cnt == sr_before, "R10 no pulse on non-zero commit", 64'(sr_cnt - sr_before), 64'd0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule